// File: doc/BRIEF.md
# In-Order Retirement Queue with Precise Flush

This block keeps the program order of the instructions that an out-of-order core has in flight. The front end claims one slot per cycle at the tail and receives that slot's index as a tag. The instruction travels with the tag, and an execution unit uses the tag to mark the slot complete, with or without a fault. The oldest slot sits at the head. It leaves the queue only when it is complete and clean, so no architectural effect becomes final before every older instruction has become final.

There are three ways to discard work. A fault on the oldest slot discards that slot and everything younger, and returns its PC so fetch can restart there. An external interrupt discards every slot in the queue, whether complete or not, and returns the PC of the oldest one. A mispredicted branch cuts the queue back to the slot just after the branch and leaves older slots alone. A store is released to the store buffer only in the cycle it retires. Head and tail pointers carry one extra wrap bit, so a full queue can be told apart from an empty one. The depth must be a power of two.

Top module: `rtq_top`

## Requirements
- R1: After reset the queue is empty, `allocReady` is 1, `allocTag` is 0, and `retireValid`, `excValid` and `intTaken` are 0.
- R2: A slot is claimed on a clock edge where `allocValid` and `allocReady` are both 1. `allocTag` gives the index of the slot the next claim will take. Successive claims take successive indices modulo DEPTH.
- R3: A slot retires only after a completion without a fault has been written to its tag. Completing a younger slot while an older one is incomplete retires nothing.
- R4: Retirement follows claim order, at most one slot per cycle. `retireValid` is high, and `retirePc` shows the head PC, during every cycle in which the head slot is complete and clean. The head advances at the end of that cycle.
- R5: Once DEPTH slots are held, `allocReady` is 0.
- R6: When the head slot is complete with a fault, `excValid` is 1 and `restartPc` shows that slot's PC, and `retireValid` is 0. At the clock edge that slot and all younger slots are discarded, so the next claim gets the faulting slot's tag.
- R7: `retireStore` is 1 only in a cycle where `retireValid` is 1 and the retiring slot was claimed with `allocIsStore` set.
- R8: When `brFlushValid` is 1, every slot younger than `brFlushTag` is discarded and the branch slot and older slots are kept. The next claim gets tag `brFlushTag`+1 modulo DEPTH. A stale completion left in a discarded slot does not carry over to a later claim of that slot.
- R9: When `intReq` is 1 and the queue is not empty, `intTaken` is 1, `restartPc` shows the head PC, nothing retires, and all slots are discarded at the clock edge. When the queue is empty, `intReq` has no effect.
- R10: In a cycle that flushes for any reason, `allocReady` is 0 and no slot is claimed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| allocValid | input | 1 | Front end requests a slot |
| allocPc | input | PC_W | PC of the instruction being claimed |
| allocIsStore | input | 1 | Instruction being claimed is a store |
| allocReady | output | 1 | A slot can be claimed this cycle |
| allocTag | output | IDX_W | Index of the slot the next claim takes |
| doneValid | input | 1 | Execution unit reports completion |
| doneTag | input | IDX_W | Tag of the completed slot |
| doneFault | input | 1 | Completed instruction faulted |
| brFlushValid | input | 1 | Branch at brFlushTag was mispredicted |
| brFlushTag | input | IDX_W | Tag of the mispredicted branch |
| intReq | input | 1 | External interrupt request |
| retireValid | output | 1 | Head slot retires this cycle |
| retirePc | output | PC_W | PC of the retiring slot |
| retireStore | output | 1 | Retiring slot's store may commit to cache |
| excValid | output | 1 | Precise exception taken at the head |
| intTaken | output | 1 | Interrupt taken, queue discarded |
| restartPc | output | PC_W | PC where fetch restarts after a flush |

## Verification
All outputs are combinational from the queue state and the flush and interrupt inputs. A completion written at edge k therefore shows up as `retireValid` or `excValid` in the cycle that follows edge k. `intTaken` and the loss of `allocReady` show up in the same cycle as their request. A new `allocTag` after a claim or flush is visible in the cycle after that edge. The bench drives its inputs 2 ns after each rising edge and samples 1 ns later, which is before the next edge. While a drain is under way it checks one retirement in every cycle, because a complete head leaves the queue with no further input.

// File: rtl/rtq_pkg.sv
package rtq_pkg;
  // strobes the control issues to the slot storage
  typedef struct packed {
    logic allocWe;   // write a new slot at the tail
    logic retireEn;  // head slot leaves the queue this cycle
  } rtq_strobe_t;
endpackage

// File: rtl/rtq_slots.sv
module rtq_slots
  import rtq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PC_W  = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  rtq_strobe_t      strb,
  input  logic [IDX_W-1:0] tailIdx,
  input  logic [IDX_W-1:0] headIdx,
  input  logic [PC_W-1:0]  allocPc,
  input  logic             allocIsStore,
  input  logic             doneValid,
  input  logic [IDX_W-1:0] doneTag,
  input  logic             doneFault,
  output logic [PC_W-1:0]  headPc,
  output logic             headStore,
  output logic             headDone,
  output logic             headFault
);
  logic [PC_W-1:0] pcQ    [DEPTH];
  logic [DEPTH-1:0] storeQ, doneQ, faultQ;

  always_ff @(posedge clk) begin
    if (strb.allocWe) begin
      pcQ[tailIdx] <= allocPc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      storeQ <= '0;
      doneQ  <= '0;
      faultQ <= '0;
    end else begin
      if (doneValid) begin
        doneQ[doneTag]  <= 1'b1;
        faultQ[doneTag] <= doneFault;
      end
      // a fresh claim overrides any stale completion in the same slot
      if (strb.allocWe) begin
        storeQ[tailIdx] <= allocIsStore;
        doneQ[tailIdx]  <= 1'b0;
        faultQ[tailIdx] <= 1'b0;
      end
    end
  end

  assign headPc    = pcQ[headIdx];
  assign headStore = storeQ[headIdx];
  assign headDone  = doneQ[headIdx];
  assign headFault = faultQ[headIdx];

  AST_RETIRE_DONE: assert property (@(posedge clk) disable iff (!rstN)
    strb.retireEn |-> (doneQ[headIdx] && !faultQ[headIdx])); // R3
endmodule

// File: rtl/rtq_ctrl.sv
module rtq_ctrl
  import rtq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             allocValid,
  input  logic             brFlushValid,
  input  logic [IDX_W-1:0] brFlushTag,
  input  logic             intReq,
  input  logic             headDone,
  input  logic             headFault,
  output rtq_strobe_t      strb,
  output logic [IDX_W-1:0] headIdx,
  output logic [IDX_W-1:0] tailIdx,
  output logic             allocReady,
  output logic             retireValid,
  output logic             excValid,
  output logic             intTaken
);
  logic [PTR_W-1:0] headPtr, tailPtr, brTail;
  logic [IDX_W-1:0] brOff;
  logic             isEmpty, isFull, flushAll, flushBr;

  assign headIdx = headPtr[IDX_W-1:0];
  assign tailIdx = tailPtr[IDX_W-1:0];
  assign isEmpty = (headPtr == tailPtr);
  assign isFull  = (headPtr[IDX_W] != tailPtr[IDX_W]) && (headIdx == tailIdx);

  always_comb begin
    excValid    = !isEmpty && headDone && headFault;
    intTaken    = intReq && !isEmpty && !excValid;
    flushAll    = excValid || intTaken;
    flushBr     = brFlushValid && !flushAll;
    retireValid = !isEmpty && headDone && !headFault && !intReq;
    allocReady  = !isFull && !flushAll && !brFlushValid;
    strb.allocWe  = allocValid && allocReady;
    strb.retireEn = retireValid;
    // the branch keeps its slot; the new tail is one past it
    brOff  = brFlushTag - headIdx;
    brTail = headPtr + {1'b0, brOff} + PTR_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headPtr <= '0;
      tailPtr <= '0;
    end else if (flushAll) begin
      tailPtr <= headPtr;
    end else begin
      if (strb.retireEn) headPtr <= headPtr + PTR_W'(1);
      if (flushBr)           tailPtr <= brTail;
      else if (strb.allocWe) tailPtr <= tailPtr + PTR_W'(1);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (tailPtr - headPtr) <= PTR_W'(DEPTH)); // R5
  AST_ALLOC_OCCUPIES: assert property (@(posedge clk) disable iff (!rstN)
    strb.allocWe |=> !isEmpty); // R2
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    flushAll |=> (headPtr == tailPtr)); // R6
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({retireValid, excValid, intTaken})); // R4
  AST_BR_KEEPS_HEAD: assert property (@(posedge clk) disable iff (!rstN)
    (flushBr && !strb.retireEn) |=> $stable(headPtr)); // R8
endmodule

// File: rtl/rtq_top.sv
module rtq_top
  import rtq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PC_W  = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             allocValid,
  input  logic [PC_W-1:0]  allocPc,
  input  logic             allocIsStore,
  output logic             allocReady,
  output logic [IDX_W-1:0] allocTag,
  input  logic             doneValid,
  input  logic [IDX_W-1:0] doneTag,
  input  logic             doneFault,
  input  logic             brFlushValid,
  input  logic [IDX_W-1:0] brFlushTag,
  input  logic             intReq,
  output logic             retireValid,
  output logic [PC_W-1:0]  retirePc,
  output logic             retireStore,
  output logic             excValid,
  output logic             intTaken,
  output logic [PC_W-1:0]  restartPc
);
  rtq_strobe_t      strb;
  logic [IDX_W-1:0] headIdx, tailIdx;
  logic [PC_W-1:0]  headPc;
  logic             headStore, headDone, headFault;

  rtq_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .allocValid(allocValid),
    .brFlushValid(brFlushValid), .brFlushTag(brFlushTag), .intReq(intReq),
    .headDone(headDone), .headFault(headFault), .strb(strb),
    .headIdx(headIdx), .tailIdx(tailIdx), .allocReady(allocReady),
    .retireValid(retireValid), .excValid(excValid), .intTaken(intTaken)
  );

  rtq_slots #(.DEPTH(DEPTH), .PC_W(PC_W)) slots_i (
    .clk(clk), .rstN(rstN), .strb(strb), .tailIdx(tailIdx), .headIdx(headIdx),
    .allocPc(allocPc), .allocIsStore(allocIsStore), .doneValid(doneValid),
    .doneTag(doneTag), .doneFault(doneFault), .headPc(headPc),
    .headStore(headStore), .headDone(headDone), .headFault(headFault)
  );

  assign allocTag    = tailIdx;
  assign retirePc    = headPc;
  assign restartPc   = headPc;
  assign retireStore = retireValid && headStore;

  AST_STORE_ON_RETIRE: assert property (@(posedge clk) disable iff (!rstN)
    retireStore |-> (retireValid && !excValid && !intTaken)); // R7
endmodule

// File: tb/rtq_top_tb.sv
module rtq_top_tb_top;
  localparam int DEPTH = 8;
  localparam int PC_W  = 32;
  localparam int IDX_W = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic allocValid = 0, allocIsStore = 0, doneValid = 0, doneFault = 0;
  logic brFlushValid = 0, intReq = 0;
  logic [PC_W-1:0] allocPc = '0;
  logic [IDX_W-1:0] doneTag = '0, brFlushTag = '0;
  logic allocReady, retireValid, retireStore, excValid, intTaken;
  logic [IDX_W-1:0] allocTag;
  logic [PC_W-1:0] retirePc, restartPc;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  rtq_top #(.DEPTH(DEPTH), .PC_W(PC_W)) dut_i (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick; @(posedge clk); #2; endtask

  task automatic doAlloc(input logic [31:0] pc, input bit st, output logic [IDX_W-1:0] tag);
    allocValid = 1; allocPc = pc; allocIsStore = st; #1;
    tag = allocTag;
    chk(allocReady == 1'b1, "R2", "allocReady", {31'b0, allocReady}, 1);
    tick; allocValid = 0; allocIsStore = 0;
  endtask

  task automatic doDone(input logic [IDX_W-1:0] tag, input bit flt);
    doneValid = 1; doneTag = tag; doneFault = flt;
    tick; doneValid = 0; doneFault = 0;
  endtask

  // expect the head to retire with this PC in the current cycle
  task automatic expRetire(input logic [31:0] pc, input bit st, input string req);
    #1;
    chk(retireValid == 1'b1, req, "retireValid", {31'b0, retireValid}, 1);
    chk(retirePc == pc, req, "retirePc", retirePc, pc);
    chk(retireStore == st, "R7", "retireStore", {31'b0, retireStore}, {31'b0, st});
    tick;
  endtask

  task automatic expIdle(input string req);
    #1;
    chk(retireValid == 1'b0, req, "retireValid idle", {31'b0, retireValid}, 0);
  endtask

  task automatic testReset;
    #1;
    chk(allocReady == 1'b1, "R1", "allocReady", {31'b0, allocReady}, 1);
    chk(allocTag == 0, "R1", "allocTag", {29'b0, allocTag}, 0);
    chk(!retireValid && !excValid && !intTaken, "R1", "outputs idle",
        {29'b0, retireValid, excValid, intTaken}, 0);
  endtask

  task automatic testOrder;
    logic [IDX_W-1:0] t0, t1, t2;
    doAlloc(32'h100, 0, t0); doAlloc(32'h104, 0, t1); doAlloc(32'h108, 0, t2);
    chk(t0 == 0 && t1 == 1 && t2 == 2, "R2", "tags", {23'b0, t0, t1, t2}, 9'o012);
    doDone(t2, 0); expIdle("R3");
    doDone(t1, 0); expIdle("R3");
    doDone(t0, 0);
    expRetire(32'h100, 0, "R4"); expRetire(32'h104, 0, "R4"); expRetire(32'h108, 0, "R4");
    expIdle("R4");
  endtask

  task automatic testFull;
    logic [IDX_W-1:0] tg [DEPTH];
    for (int i = 0; i < DEPTH; i++) begin
      doAlloc(32'h200 + 4*i, 0, tg[i]);
      chk(tg[i] == IDX_W'(3 + i), "R2", "wrapped tag", {29'b0, tg[i]}, (3 + i) % DEPTH);
    end
    allocValid = 1; #1;
    chk(allocReady == 1'b0, "R5", "allocReady when full", {31'b0, allocReady}, 0);
    tick; allocValid = 0;
    for (int i = DEPTH - 1; i >= 0; i--) doDone(tg[i], 0);
    for (int i = 0; i < DEPTH; i++) expRetire(32'h200 + 4*i, 0, "R4");
    expIdle("R4");
  endtask

  task automatic testFault;
    logic [IDX_W-1:0] ta, tb, tc;
    doAlloc(32'h300, 0, ta); doAlloc(32'h304, 0, tb); doAlloc(32'h308, 0, tc);
    doDone(tc, 0); doDone(tb, 1); expIdle("R6");
    chk(excValid == 1'b0, "R6", "no exc while fault not at head", {31'b0, excValid}, 0);
    doDone(ta, 0);
    expRetire(32'h300, 0, "R6");
    #1;
    chk(excValid == 1'b1, "R6", "excValid", {31'b0, excValid}, 1);
    chk(restartPc == 32'h304, "R6", "restartPc", restartPc, 32'h304);
    chk(retireValid == 1'b0, "R6", "no retire on fault", {31'b0, retireValid}, 0);
    tick; #1;
    chk(excValid == 1'b0 && retireValid == 1'b0, "R6", "flushed",
        {30'b0, excValid, retireValid}, 0);
    chk(allocTag == tb, "R6", "tail at faulting tag", {29'b0, allocTag}, {29'b0, tb});
  endtask

  task automatic testStore;
    logic [IDX_W-1:0] tl, ts;
    doAlloc(32'h400, 0, tl); doAlloc(32'h404, 1, ts);
    doDone(ts, 0); #1;
    chk(retireStore == 1'b0, "R7", "store held behind incomplete load",
        {31'b0, retireStore}, 0);
    doDone(tl, 0);
    expRetire(32'h400, 0, "R7"); expRetire(32'h404, 1, "R7");
    expIdle("R7");
  endtask

  task automatic testBranch;
    logic [IDX_W-1:0] tx, ty, tz, tw, tn;
    doAlloc(32'h500, 0, tx); doAlloc(32'h504, 0, ty);
    doAlloc(32'h508, 0, tz); doAlloc(32'h50c, 0, tw);
    doDone(tz, 0);
    brFlushValid = 1; brFlushTag = ty; allocValid = 1; allocPc = 32'hdead; #1;
    chk(allocReady == 1'b0, "R10", "alloc blocked by flush", {31'b0, allocReady}, 0);
    tick; brFlushValid = 0; allocValid = 0; #1;
    chk(allocTag == IDX_W'(ty + 1), "R8", "tail after branch", {29'b0, allocTag},
        {29'b0, IDX_W'(ty + 1)});
    doDone(tx, 0); doDone(ty, 0);
    // both survivors may already be retiring; the head retired x during ty's completion
    expRetire(32'h504, 0, "R8");
    expIdle("R8");
    doAlloc(32'h600, 0, tn);
    chk(tn == tz, "R8", "reuse of flushed slot", {29'b0, tn}, {29'b0, tz});
    expIdle("R8");
    doDone(tn, 0);
    expRetire(32'h600, 0, "R8");
  endtask

  task automatic testInterrupt;
    logic [IDX_W-1:0] tp, tq;
    intReq = 1; #1;
    chk(intTaken == 1'b0, "R9", "interrupt on empty queue", {31'b0, intTaken}, 0);
    tick; intReq = 0;
    doAlloc(32'h700, 0, tp); doAlloc(32'h704, 0, tq);
    intReq = 1; allocValid = 1; #1;
    chk(intTaken == 1'b1, "R9", "intTaken", {31'b0, intTaken}, 1);
    chk(restartPc == 32'h700, "R9", "restartPc", restartPc, 32'h700);
    chk(allocReady == 1'b0, "R10", "alloc blocked by interrupt", {31'b0, allocReady}, 0);
    tick; intReq = 0; allocValid = 0; #1;
    chk(allocTag == tp, "R9", "queue discarded", {29'b0, allocTag}, {29'b0, tp});
    doDone(tq, 0); expIdle("R9");
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1;
    testReset();
    testOrder();
    testFull();
    testFault();
    testStore();
    testBranch();
    testInterrupt();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule